// File: doc/BRIEF.md
# Floating-Point Unit Status and Control Register

This block is the 32-bit status and control word of a single-precision floating-point unit. It holds four comparison condition flags, the mode controls that steer the arithmetic datapath (a two-bit rounding mode, a flush-to-zero enable and a default-NaN enable) and a set of cumulative exception bits. The mode fields leave the block as dedicated outputs to the datapath. The condition flags are loaded only by compare results or by a full-word write. The exception bits gather the per-operation exception pulses from the arithmetic units by OR-ing them in, and they stay set until software writes them to zero.

The integer core reaches the register through a full-word write port and a read port. Each transfer serialises against floating-point work. The block counts operations that have issued but not yet retired. While that count is nonzero it raises a stall, and it grants neither reads nor writes, so a transfer sees or alters the state only after every earlier operation has finished. Operations issued later see the new modes. A typical use is a read, an OR or clear of the rounding field in an integer register, and a write back.

Top module: `fpu_csr`

## Requirements
- R1: After reset the read word is 0x00000000, all mode outputs are 0 and stall_o is low.
- R2: Only bits 31:28, 25:22, 7 and 4:0 are storage. Every other bit reads as zero and ignores written values, so a write of 0xFFFFFFFF reads back 0xF3C0009F.
- R3: A write is granted (wr_gnt_o) only while stall_o is low. In the cycle after a granted write the read word equals the written data with the reserved bits cleared.
- R4: A read is granted (rd_gnt_o) only while stall_o is low.
- R5: The condition flags N, Z, C and V (bits 31, 30, 29, 28) change only on a compare result or a granted write. Exception pulses leave them unchanged.
- R6: A compare result (cmp_vld_i with cmp_nzcv_i ordered N, Z, C, V from the MSB down) loads bits 31:28 in the next cycle.
- R7: Exception bits are sticky. A pulse on exc_i ORs into the stored bits, and only a granted write can clear them.
- R8: An overflow pulse (exc_i bit 2) also sets inexact (bit 4).
- R9: The exc_i bits map to the register as follows: 0 invalid to bit 0, 1 divide-by-zero to bit 1, 2 overflow to bit 2, 3 underflow to bit 3, 4 inexact to bit 4, and 5 input-denormal to bit 7.
- R10: When a granted write, a compare result and exception pulses share a cycle, the register takes the write data alone.
- R11: rmode_o shows bits 23:22 (00 round to nearest, 11 round toward zero), ftz_o shows bit 24 and dn_o shows bit 25. They change only on a granted write, so a read-modify-write of the rounding field takes effect from the next cycle.
- R12: issue_i raises the in-flight count by one and retire_i lowers it by one. When both arrive in one cycle the count stays the same. stall_o is high exactly while the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | One FP operation issued this cycle |
| retire_i | input | 1 | One FP operation retired this cycle |
| cmp_vld_i | input | 1 | Compare result valid |
| cmp_nzcv_i | input | 4 | Compare flags N, Z, C, V (MSB first) |
| exc_i | input | 6 | Exception pulses: invalid, div-by-zero, overflow, underflow, inexact, input-denormal (bit 0 up) |
| wr_req_i | input | 1 | Write request from the integer core |
| wr_data_i | input | 32 | Full-word write data |
| wr_gnt_o | output | 1 | Write accepted this cycle |
| rd_req_i | input | 1 | Read request from the integer core |
| rd_gnt_o | output | 1 | Read accepted, rd_data_o valid |
| rd_data_o | output | 32 | Current register word |
| rmode_o | output | 2 | Rounding mode to the datapath |
| ftz_o | output | 1 | Flush-to-zero enable |
| dn_o | output | 1 | Default-NaN enable |
| stall_o | output | 1 | Operations are in flight, so transfers wait |

## Verification
A wrong stored field shows at rd_data_o and, for the modes, at rmode_o, ftz_o and dn_o one cycle after the event that corrupted it. It stays visible until the next write, because nothing else restores it. A miscounted in-flight number shows at stall_o and at the grant outputs in the same cycle: the grant arrives too early, before the last retire, or never arrives. Lost or misplaced exception pulses show up as missing or shifted bits in the word read after the pulse, and a flag overwritten by a pulse or by a write that was not granted shows up the same way.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned NZCV_W   = 4;
    localparam int unsigned RMODE_W  = 2;
    localparam int unsigned EXC_W    = 5;
    localparam int unsigned PULSE_W  = EXC_W + 1;

    // Field positions in the register word
    localparam int unsigned NZCV_LSB  = 28;
    localparam int unsigned DN_BIT    = 25;
    localparam int unsigned FTZ_BIT   = 24;
    localparam int unsigned RMODE_LSB = 22;
    localparam int unsigned IDC_BIT   = 7;
    localparam int unsigned EXC_LSB   = 0;

    // Pulse indices
    localparam int unsigned P_INV  = 0;
    localparam int unsigned P_DZ   = 1;
    localparam int unsigned P_OVF  = 2;
    localparam int unsigned P_UNF  = 3;
    localparam int unsigned P_INX  = 4;
    localparam int unsigned P_IDN  = 5;

    localparam logic [WORD_W-1:0] WR_MASK = 32'hF3C0_009F;

    typedef struct packed {
        logic [NZCV_W-1:0]  nzcv;
        logic               dn;
        logic               ftz;
        logic [RMODE_W-1:0] rmode;
        logic               idc;
        logic [EXC_W-1:0]   exc;
    } csr_state_t;

    function automatic csr_state_t unpack_word(input logic [WORD_W-1:0] w);
        csr_state_t s;
        s.nzcv  = w[NZCV_LSB +: NZCV_W];
        s.dn    = w[DN_BIT];
        s.ftz   = w[FTZ_BIT];
        s.rmode = w[RMODE_LSB +: RMODE_W];
        s.idc   = w[IDC_BIT];
        s.exc   = w[EXC_LSB +: EXC_W];
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input csr_state_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[NZCV_LSB +: NZCV_W]   = s.nzcv;
        w[DN_BIT]               = s.dn;
        w[FTZ_BIT]              = s.ftz;
        w[RMODE_LSB +: RMODE_W] = s.rmode;
        w[IDC_BIT]              = s.idc;
        w[EXC_LSB +: EXC_W]     = s.exc;
        return w;
    endfunction

endpackage

// File: rtl/fcsr_inflight_ctr.sv
module fcsr_inflight_ctr #(
    parameter int unsigned MAX_INFLIGHT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic retire_i,
    output logic busy_o
);
    localparam int unsigned CNT_W = $clog2(MAX_INFLIGHT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INFLIGHT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({issue_i, retire_i})
            2'b10: if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            2'b01: if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/fcsr_exc_merge.sv
module fcsr_exc_merge
    import fcsr_pkg::*;
(
    input  logic [PULSE_W-1:0] exc_i,
    input  logic [EXC_W-1:0]   exc_q_i,
    input  logic               idc_q_i,
    output logic [EXC_W-1:0]   exc_d_o,
    output logic               idc_d_o
);
    logic [EXC_W-1:0] set_vec;

    for (genvar i = 0; i < EXC_W; i++) begin : g_bit
        if (i == P_INX) begin : g_inx
            // overflow always implies inexact
            assign set_vec[i] = exc_i[i] | exc_i[P_OVF];
        end else begin : g_plain
            assign set_vec[i] = exc_i[i];
        end
    end

    assign exc_d_o = exc_q_i | set_vec;
    assign idc_d_o = idc_q_i | exc_i[P_IDN];

endmodule

// File: rtl/fpu_csr.sv
module fpu_csr
    import fcsr_pkg::*;
#(
    parameter int unsigned MAX_INFLIGHT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_i,
    input  logic                 retire_i,
    input  logic                 cmp_vld_i,
    input  logic [3:0]           cmp_nzcv_i,
    input  logic [5:0]           exc_i,
    input  logic                 wr_req_i,
    input  logic [31:0]          wr_data_i,
    output logic                 wr_gnt_o,
    input  logic                 rd_req_i,
    output logic                 rd_gnt_o,
    output logic [31:0]          rd_data_o,
    output logic [1:0]           rmode_o,
    output logic                 ftz_o,
    output logic                 dn_o,
    output logic                 stall_o
);
    csr_state_t st_d, st_q;
    logic       busy;
    logic [EXC_W-1:0] exc_merged;
    logic       idc_merged;

    fcsr_inflight_ctr #(
        .MAX_INFLIGHT(MAX_INFLIGHT)
    ) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue_i),
        .retire_i (retire_i),
        .busy_o   (busy)
    );

    fcsr_exc_merge i_merge (
        .exc_i   (exc_i),
        .exc_q_i (st_q.exc),
        .idc_q_i (st_q.idc),
        .exc_d_o (exc_merged),
        .idc_d_o (idc_merged)
    );

    assign wr_gnt_o = wr_req_i & ~busy;
    assign rd_gnt_o = rd_req_i & ~busy;
    assign stall_o  = busy;

    always_comb begin
        st_d = st_q;
        if (wr_gnt_o) begin
            st_d = unpack_word(wr_data_i & WR_MASK);
        end else begin
            if (cmp_vld_i) st_d.nzcv = cmp_nzcv_i;
            st_d.exc = exc_merged;
            st_d.idc = idc_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = pack_word(st_q);
    assign rmode_o   = st_q.rmode;
    assign ftz_o     = st_q.ftz;
    assign dn_o      = st_q.dn;

endmodule

// File: rtl/fcsr_checker.sv
module fcsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        retire_i,
    input logic        issue_i,
    input logic        cmp_vld_i,
    input logic [3:0]  cmp_nzcv_i,
    input logic [5:0]  exc_i,
    input logic        wr_req_i,
    input logic [31:0] wr_data_i,
    input logic        wr_gnt_o,
    input logic        rd_req_i,
    input logic        rd_gnt_o,
    input logic [31:0] rd_data_o,
    input logic [1:0]  rmode_o,
    input logic        ftz_o,
    input logic        dn_o,
    input logic        stall_o
);
    localparam logic [31:0] KEEP = 32'hF3C0_009F;
    localparam logic [31:0] EXCM = 32'h0000_009F;

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~KEEP) == 32'h0);

    p_wr_serial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gnt_o |-> !stall_o);

    p_rd_serial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt_o |-> !stall_o);

    p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_vld_i && !wr_gnt_o) |=> $stable(rd_data_o[31:28]));

    p_cmp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld_i && !wr_gnt_o) |=> rd_data_o[31:28] == $past(cmp_nzcv_i));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gnt_o |=> ((rd_data_o & EXCM) & $past(rd_data_o & EXCM)) == $past(rd_data_o & EXCM));

    p_ovf_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_i[2] && !wr_gnt_o) |=> (rd_data_o[2] && rd_data_o[4]));

    p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gnt_o |=> rd_data_o == ($past(wr_data_i) & KEEP));

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gnt_o |=> $stable({rmode_o, ftz_o, dn_o}));

    p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !issue_i) |-> stall_o);

endmodule

bind fpu_csr fcsr_checker i_fcsr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_i   (retire_i),
    .issue_i    (issue_i),
    .cmp_vld_i  (cmp_vld_i),
    .cmp_nzcv_i (cmp_nzcv_i),
    .exc_i      (exc_i),
    .wr_req_i   (wr_req_i),
    .wr_data_i  (wr_data_i),
    .wr_gnt_o   (wr_gnt_o),
    .rd_req_i   (rd_req_i),
    .rd_gnt_o   (rd_gnt_o),
    .rd_data_o  (rd_data_o),
    .rmode_o    (rmode_o),
    .ftz_o      (ftz_o),
    .dn_o       (dn_o),
    .stall_o    (stall_o)
);

// File: tb/test_fpu_csr.sv
module test_fpu_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0, retire_i = 1'b0, cmp_vld_i = 1'b0;
    logic [3:0]  cmp_nzcv_i = '0;
    logic [5:0]  exc_i = '0;
    logic        wr_req_i = 1'b0, rd_req_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        wr_gnt_o, rd_gnt_o, ftz_o, dn_o, stall_o;
    logic [31:0] rd_data_o;
    logic [1:0]  rmode_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpu_csr i_fpu_csr (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .retire_i(retire_i),
        .cmp_vld_i(cmp_vld_i), .cmp_nzcv_i(cmp_nzcv_i), .exc_i(exc_i),
        .wr_req_i(wr_req_i), .wr_data_i(wr_data_i), .wr_gnt_o(wr_gnt_o),
        .rd_req_i(rd_req_i), .rd_gnt_o(rd_gnt_o), .rd_data_o(rd_data_o),
        .rmode_o(rmode_o), .ftz_o(ftz_o), .dn_o(dn_o), .stall_o(stall_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one clock; inputs change and outputs are sampled 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_word(input logic [31:0] d);
        wr_req_i = 1'b1; wr_data_i = d;
        step();
        wr_req_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 word", rd_data_o, 32'h0);
        chk("R1 modes", {28'h0, rmode_o, ftz_o, dn_o}, 32'h0);
        chk("R1 stall", {31'h0, stall_o}, 32'h0);
    endtask

    task automatic t_mask();
        wr_word(32'hFFFF_FFFF);
        chk("R2 reserved masked", rd_data_o, 32'hF3C0_009F);
        chk("R11 modes after all-ones", {28'h0, rmode_o, ftz_o, dn_o}, 32'hF);
        wr_word(32'h0C3F_FF60);
        chk("R2 reserved only write", rd_data_o, 32'h0);
    endtask

    task automatic t_rmode();
        logic [31:0] v;
        rd_req_i = 1'b1; #0.5;
        chk("R4 read granted idle", {31'h0, rd_gnt_o}, 32'h1);
        v = rd_data_o;
        rd_req_i = 1'b0;
        wr_word(v | 32'h00C0_0000);
        chk("R11 rmode toward zero", {30'h0, rmode_o}, 32'h3);
        chk("R3 rmw word", rd_data_o, 32'h00C0_0000);
        wr_word(rd_data_o & ~32'h00C0_0000);
        chk("R11 rmode nearest", {30'h0, rmode_o}, 32'h0);
        wr_word(32'h0100_0000);
        chk("R11 ftz", {30'h0, ftz_o, dn_o}, 32'h2);
        wr_word(32'h0200_0000);
        chk("R11 dn", {30'h0, ftz_o, dn_o}, 32'h1);
        exc_i = 6'h3F; cmp_vld_i = 1'b1; cmp_nzcv_i = 4'h5;
        step();
        exc_i = '0; cmp_vld_i = 1'b0;
        chk("R11 modes hold on pulses", {30'h0, ftz_o, dn_o}, 32'h1);
        wr_word(32'h0);
    endtask

    task automatic t_compare();
        cmp_vld_i = 1'b1; cmp_nzcv_i = 4'b1000;
        step();
        chk("R6 less-than flags", rd_data_o, 32'h8000_0000);
        cmp_nzcv_i = 4'b0011;
        step();
        cmp_vld_i = 1'b0;
        chk("R6 unordered flags", rd_data_o, 32'h3000_0000);
        exc_i = 6'b000001;
        step();
        exc_i = '0;
        chk("R5 flags hold on pulse", rd_data_o, 32'h3000_0001);
        wr_word(32'h0);
    endtask

    task automatic t_sticky();
        exc_i = 6'b000001; step();
        chk("R9 invalid bit0", rd_data_o, 32'h1);
        exc_i = 6'b100000; step();
        chk("R9 input-denormal bit7", rd_data_o, 32'h81);
        exc_i = 6'b001000; step();
        chk("R9 underflow bit3", rd_data_o, 32'h89);
        exc_i = 6'b000010; step();
        exc_i = '0;
        chk("R9 divzero bit1", rd_data_o, 32'h8B);
        step(); step();
        chk("R7 sticky hold", rd_data_o, 32'h8B);
        wr_word(32'h0);
        chk("R7 cleared by write", rd_data_o, 32'h0);
        exc_i = 6'b000100; step();
        exc_i = '0;
        chk("R8 overflow sets inexact", rd_data_o, 32'h14);
        wr_word(32'h0);
    endtask

    task automatic t_serial();
        issue_i = 1'b1; step(); step();
        issue_i = 1'b0;
        chk("R12 stall with two in flight", {31'h0, stall_o}, 32'h1);
        wr_req_i = 1'b1; wr_data_i = 32'h00C0_0000; rd_req_i = 1'b1; #0.5;
        chk("R3 write held", {31'h0, wr_gnt_o}, 32'h0);
        chk("R4 read held", {31'h0, rd_gnt_o}, 32'h0);
        issue_i = 1'b1; retire_i = 1'b1; step();
        issue_i = 1'b0;
        chk("R12 issue+retire keeps stall", {31'h0, stall_o}, 32'h1);
        chk("R3 no write while stalled", rd_data_o, 32'h0);
        step();
        chk("R12 one left", {31'h0, stall_o}, 32'h1);
        step();
        retire_i = 1'b0; #0.5;
        chk("R12 stall drops", {31'h0, stall_o}, 32'h0);
        chk("R3 write granted", {31'h0, wr_gnt_o}, 32'h1);
        chk("R4 read granted", {31'h0, rd_gnt_o}, 32'h1);
        step();
        wr_req_i = 1'b0; rd_req_i = 1'b0;
        chk("R3 write landed", rd_data_o, 32'h00C0_0000);
    endtask

    task automatic t_priority();
        exc_i = 6'b000101; step();
        exc_i = '0;
        chk("R10 setup", rd_data_o, 32'h00C0_0015);
        wr_req_i = 1'b1; wr_data_i = 32'h4000_0000;
        exc_i = 6'b111111; cmp_vld_i = 1'b1; cmp_nzcv_i = 4'b0011;
        step();
        wr_req_i = 1'b0; exc_i = '0; cmp_vld_i = 1'b0;
        chk("R10 write wins", rd_data_o, 32'h4000_0000);
        chk("R10 rmode from write", {30'h0, rmode_o}, 32'h0);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_mask();
        t_rmode();
        t_compare();
        t_sticky();
        t_serial();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule